// File: doc/BRIEF.md
# Bit-Count, Logic and Pack Unit

A purely combinational execution unit for a 64-bit integer datapath. It takes two source operands and a 5-bit operation code and returns one result in the same cycle. It covers three groups of operations: counting (leading zeros, trailing zeros and set bits, each over the full operand and over the low word), two-operand logic (logic with an inverted operand, signed and unsigned minimum and maximum), and reshaping (byte and halfword sign extension, and four ways of merging slices of the two operands).

Instruction decode happens upstream and maps each instruction onto an operation code. Operand fetch is also upstream. The unit itself holds no state. Codes that name no operation return zero and raise a flag, so the surrounding pipeline can trap on them.

Top module: `bitmanip_basic_unit`

## Requirements
- R1: Code 0 returns the number of leading zeros of `src_a_i`, and code 1 returns the number of trailing zeros. Both return 64 when the operand is zero.
- R2: Code 2 returns the number of set bits in all 64 bits of `src_a_i`. Code 5 counts only bits 31:0.
- R3: Code 3 returns the number of leading zeros of bits 31:0, and code 4 returns the number of trailing zeros of bits 31:0. Both return 32 when those bits are zero, and bits 63:32 have no effect on either.
- R4: Code 6 returns a AND NOT b, code 7 returns a OR NOT b, and code 8 returns NOT (a XOR b).
- R5: Code 9 returns the signed minimum of the two operands, and code 10 returns the signed maximum.
- R6: Code 11 returns the unsigned minimum of the two operands, and code 12 returns the unsigned maximum.
- R7: Code 13 sign-extends bit 7 of `src_a_i` to 64 bits, and code 14 sign-extends bit 15.
- R8: Code 15 returns {b[31:0], a[31:0]}, and code 16 returns {b[63:32], a[63:32]}.
- R9: Code 17 returns a[7:0] in bits 7:0 and b[7:0] in bits 15:8, with bits 63:16 zero.
- R10: Code 18 forms {b[15:0], a[15:0]} in bits 31:0 and copies bit 31 into bits 63:32.
- R11: Codes 19 to 31 return zero with `illegal_o` high. Codes 0 to 18 drive `illegal_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| src_a_i | input | 64 | First source operand |
| src_b_i | input | 64 | Second source operand |
| result_o | output | 64 | Result of the selected operation |
| illegal_o | output | 1 | High when the code names no operation |

## Verification
The bench builds the unit with its default width of 64. The word width is therefore 32, and the word forms and the pack splits fall on bit 32. At this width the checks reach the counts at their limits (64 and 32), the sign boundary at bit 63 for signed compares, and upper-word bits that must be ignored by the word counts. Each of the 32 codes is run against operands of all zeros, all ones, every single set bit, sign-boundary values and random data.

// File: rtl/bitmanip_pkg.sv
package bitmanip_pkg;
  typedef enum logic [4:0] {
    OP_LZC   = 5'd0,
    OP_TZC   = 5'd1,
    OP_POP   = 5'd2,
    OP_LZCW  = 5'd3,
    OP_TZCW  = 5'd4,
    OP_POPW  = 5'd5,
    OP_ANDI  = 5'd6,
    OP_ORI   = 5'd7,
    OP_XNOR  = 5'd8,
    OP_SMIN  = 5'd9,
    OP_SMAX  = 5'd10,
    OP_UMIN  = 5'd11,
    OP_UMAX  = 5'd12,
    OP_SXB   = 5'd13,
    OP_SXH   = 5'd14,
    OP_PLO   = 5'd15,
    OP_PHI   = 5'd16,
    OP_PBYTE = 5'd17,
    OP_PWORD = 5'd18
  } op_e;

  localparam int unsigned OP_LAST = 18;
endpackage

// File: rtl/bit_count.sv
module bit_count #(
  parameter int unsigned W  = 64,
  localparam int unsigned CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] lead_o,
  output logic [CW-1:0] trail_o,
  output logic [CW-1:0] ones_o
);
  logic hit_l, hit_t;

  always_comb begin
    lead_o = CW'(W);
    hit_l  = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit_l && val_i[i]) begin
        lead_o = CW'(W - 1 - i);
        hit_l  = 1'b1;
      end
    end
  end

  always_comb begin
    trail_o = CW'(W);
    hit_t   = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!hit_t && val_i[i]) begin
        trail_o = CW'(i);
        hit_t   = 1'b1;
      end
    end
  end

  always_comb begin
    ones_o = '0;
    for (int i = 0; i < W; i++) ones_o = ones_o + CW'(val_i[i]);
  end
endmodule

// File: rtl/logic_cmp.sv
module logic_cmp
  import bitmanip_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  logic a_lt_s, a_lt_u;

  assign a_lt_s = $signed(a_i) < $signed(b_i);
  assign a_lt_u = a_i < b_i;

  always_comb begin
    unique case (op_i)
      OP_ANDI: res_o = a_i & ~b_i;
      OP_ORI:  res_o = a_i | ~b_i;
      OP_XNOR: res_o = ~(a_i ^ b_i);
      OP_SMIN: res_o = a_lt_s ? a_i : b_i;
      OP_SMAX: res_o = a_lt_s ? b_i : a_i;
      OP_UMIN: res_o = a_lt_u ? a_i : b_i;
      OP_UMAX: res_o = a_lt_u ? b_i : a_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/pack_ext.sv
module pack_ext
  import bitmanip_pkg::*;
#(
  parameter int unsigned W  = 64,
  localparam int unsigned HW = W / 2,
  localparam int unsigned QW = W / 4
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_SXB:   res_o = {{(W-8){a_i[7]}}, a_i[7:0]};
      OP_SXH:   res_o = {{(W-16){a_i[15]}}, a_i[15:0]};
      OP_PLO:   res_o = {b_i[HW-1:0], a_i[HW-1:0]};
      OP_PHI:   res_o = {b_i[W-1:HW], a_i[W-1:HW]};
      OP_PBYTE: res_o = {{(W-16){1'b0}}, b_i[7:0], a_i[7:0]};
      // join halfwords into a word, then sign-extend it
      OP_PWORD: res_o = {{HW{b_i[QW-1]}}, b_i[QW-1:0], a_i[QW-1:0]};
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/bitmanip_basic_unit.sv
module bitmanip_basic_unit
  import bitmanip_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned WLEN = XLEN / 2,
  localparam int unsigned FCW  = $clog2(XLEN) + 1,
  localparam int unsigned WCW  = $clog2(WLEN) + 1
) (
  input  logic [4:0]      op_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  op_e             op;
  logic [FCW-1:0]  f_lead, f_trail, f_ones;
  logic [WCW-1:0]  w_lead, w_trail, w_ones;
  logic [XLEN-1:0] lc_res, pk_res;

  assign op = op_e'(op_i);

  bit_count #(.W(XLEN)) u_cnt_full (
    .val_i   (src_a_i),
    .lead_o  (f_lead),
    .trail_o (f_trail),
    .ones_o  (f_ones)
  );

  bit_count #(.W(WLEN)) u_cnt_word (
    .val_i   (src_a_i[WLEN-1:0]),
    .lead_o  (w_lead),
    .trail_o (w_trail),
    .ones_o  (w_ones)
  );

  logic_cmp #(.W(XLEN)) u_logic (
    .op_i  (op),
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .res_o (lc_res)
  );

  pack_ext #(.W(XLEN)) u_pack (
    .op_i  (op),
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .res_o (pk_res)
  );

  always_comb begin
    illegal_o = 1'b0;
    unique case (op)
      OP_LZC:  result_o = XLEN'(f_lead);
      OP_TZC:  result_o = XLEN'(f_trail);
      OP_POP:  result_o = XLEN'(f_ones);
      OP_LZCW: result_o = XLEN'(w_lead);
      OP_TZCW: result_o = XLEN'(w_trail);
      OP_POPW: result_o = XLEN'(w_ones);
      OP_ANDI, OP_ORI, OP_XNOR, OP_SMIN, OP_SMAX, OP_UMIN, OP_UMAX:
               result_o = lc_res;
      OP_SXB, OP_SXH, OP_PLO, OP_PHI, OP_PBYTE, OP_PWORD:
               result_o = pk_res;
      default: begin
        result_o  = '0;
        illegal_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/bitmanip_basic_unit_chk.sv
module bitmanip_basic_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic [4:0]      op_i,
  input logic [XLEN-1:0] src_a_i,
  input logic [XLEN-1:0] src_b_i,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o
);
  localparam int unsigned WLEN = XLEN / 2;

  always_comb begin
    if (op_i <= 5'd2)
      AST_FULL_COUNT_RANGE: assert (result_o <= XLEN) else $error("full count out of range"); // R1
    if (op_i >= 5'd3 && op_i <= 5'd5)
      AST_WORD_COUNT_RANGE: assert (result_o <= WLEN) else $error("word count out of range"); // R3
    if (op_i == 5'd11 || op_i == 5'd12)
      AST_UMINMAX_PICKS_SRC: assert (result_o == src_a_i || result_o == src_b_i) else $error("umin/umax not a source"); // R6
    if (op_i == 5'd13)
      AST_SXB_UPPER: assert (result_o[XLEN-1:8] == {(XLEN-8){result_o[7]}}) else $error("sext byte upper"); // R7
    if (op_i == 5'd17)
      AST_PBYTE_UPPER_ZERO: assert (result_o[XLEN-1:16] == '0) else $error("packh upper"); // R9
    if (op_i == 5'd18)
      AST_PWORD_SIGN: assert (result_o[XLEN-1:WLEN] == {WLEN{result_o[WLEN-1]}}) else $error("packw sign"); // R10
    if (illegal_o)
      AST_ILLEGAL_ZERO: assert (result_o == '0 && op_i > 5'd18) else $error("illegal result"); // R11
  end
endmodule

bind bitmanip_basic_unit bitmanip_basic_unit_chk #(.XLEN(XLEN)) u_chk (
  .op_i      (op_i),
  .src_a_i   (src_a_i),
  .src_b_i   (src_b_i),
  .result_o  (result_o),
  .illegal_o (illegal_o)
);

// File: tb/bitmanip_basic_unit_tb.sv
module bitmanip_basic_unit_tb;
  typedef struct {
    logic [4:0]  op;
    logic [63:0] exp;
    logic        ill;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  op_r = '0;
  logic [63:0] a_r = '0, b_r = '0;
  logic [63:0] res_w;
  logic        ill_w;
  item_t       q[$];
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  bitmanip_basic_unit u_dut (
    .op_i(op_r), .src_a_i(a_r), .src_b_i(b_r),
    .result_o(res_w), .illegal_o(ill_w)
  );

  function automatic string tag(input logic [4:0] op);
    case (op)
      5'd0, 5'd1:   return "R1";
      5'd2, 5'd5:   return "R2";
      5'd3, 5'd4:   return "R3";
      5'd6, 5'd7, 5'd8: return "R4";
      5'd9, 5'd10:  return "R5";
      5'd11, 5'd12: return "R6";
      5'd13, 5'd14: return "R7";
      5'd15, 5'd16: return "R8";
      5'd17:        return "R9";
      5'd18:        return "R10";
      default:      return "R11";
    endcase
  endfunction

  function automatic logic [63:0] lead0(input logic [63:0] v, input int n);
    int c = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) break;
      c++;
    end
    return 64'(c);
  endfunction

  function automatic logic [63:0] trail0(input logic [63:0] v);
    int c = 0;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) break;
      c++;
    end
    return 64'(c);
  endfunction

  function automatic logic [63:0] ones(input logic [63:0] v);
    int c = 0;
    for (int i = 0; i < 64; i++) c += int'(v[i]);
    return 64'(c);
  endfunction

  function automatic item_t model(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b);
    item_t it;
    logic [31:0] w;
    it.op = op; it.ill = 1'b0;
    case (op)
      5'd0:  it.exp = lead0(a, 64);
      5'd1:  it.exp = trail0(a);
      5'd2:  it.exp = ones(a);
      5'd3:  it.exp = lead0({32'h0, a[31:0]}, 32);
      5'd4:  it.exp = trail0({32'hffff_ffff, a[31:0]});
      5'd5:  it.exp = ones({32'h0, a[31:0]});
      5'd6:  it.exp = a & ~b;
      5'd7:  it.exp = a | ~b;
      5'd8:  it.exp = ~(a ^ b);
      5'd9:  it.exp = ($signed(a) < $signed(b)) ? a : b;
      5'd10: it.exp = ($signed(a) > $signed(b)) ? a : b;
      5'd11: it.exp = (a < b) ? a : b;
      5'd12: it.exp = (a > b) ? a : b;
      5'd13: it.exp = 64'($signed(a[7:0]));
      5'd14: it.exp = 64'($signed(a[15:0]));
      5'd15: it.exp = {b[31:0], a[31:0]};
      5'd16: it.exp = {b[63:32], a[63:32]};
      5'd17: it.exp = {48'h0, b[7:0], a[7:0]};
      5'd18: begin w = {b[15:0], a[15:0]}; it.exp = 64'($signed(w)); end
      default: begin it.exp = '0; it.ill = 1'b1; end
    endcase
    return it;
  endfunction

  task automatic drive(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op_r = op; a_r = a; b_r = b;
    q.push_back(model(op, a, b));
    @(posedge clk);
  endtask

  task automatic all_ops(input logic [63:0] a, input logic [63:0] b);
    for (int k = 0; k < 32; k++) drive(5'(k), a, b);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    if (rst_ni && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (res_w !== it.exp || ill_w !== it.ill) begin
        n_bad++;
        $display("FAIL %s op=%0d a=%h b=%h result=%h/%b expected=%h/%b",
                 tag(it.op), it.op, a_r, b_r, res_w, ill_w, it.exp, it.ill);
      end
    end
  end

  logic [63:0] corner [8];

  initial begin
    corner[0] = 64'h0;
    corner[1] = 64'hffff_ffff_ffff_ffff;
    corner[2] = 64'h8000_0000_0000_0000;
    corner[3] = 64'h7fff_ffff_ffff_ffff;
    corner[4] = 64'hffff_ffff_0000_0000;
    corner[5] = 64'h0000_0000_8000_0000;
    corner[6] = 64'h0000_0000_0000_8080;
    corner[7] = 64'h1234_5678_9abc_def0;
    repeat (4) @(posedge clk);
    rst_ni = 1'b1;
    drive(5'd0, 64'h0, 64'h0);             // R1: zero operand after reset gives 64
    drive(5'd4, 64'hffff_ffff_0000_0000, 0); // R3: upper word ignored, gives 32
    drive(5'd25, 64'hffff, 64'hffff);      // R11: unused code
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) all_ops(corner[i], corner[j]);
    for (int k = 0; k < 64; k++) begin
      all_ops(64'h1 << k, 64'h1 << (63 - k));
      all_ops(~(64'h1 << k), 64'h1 << k);
    end
    for (int n = 0; n < 1500; n++)
      all_ops({$urandom, $urandom}, {$urandom, $urandom});
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule